// File: doc/BRIEF.md
# Byte-Streaming Packet Port

This block is the device side of a small network port that a host processor sees as a window of 32-bit registers. The host reads a received packet one byte at a time through a single-byte read port. Each read pops the next byte and lowers the receive count. To send, the host writes a byte count and then writes that many bytes to a single-byte write port. The host also has an identification word, a busy flag, an interrupt control register with set, clear and test semantics, and a read-only interrupt routing value.

On the network side there are two valid/ready byte streams. The inbound stream carries one packet at a time, ended by a last marker. A byte moves on a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` stays low while a received packet is still waiting for the host, so the sender holds its byte and its marker until the port is ready. The outbound stream presents queued bytes with `tx_valid`. A byte stays on `tx_data`, together with its `tx_last`, until `tx_ready` takes it. Back-pressure on the outbound stream fills a small transmit queue. Once the queue is full, host writes to the transmit data port are dropped.

Host accesses use a plain synchronous port. A request is one cycle with `host_sel` high. Read data is registered and is valid on the cycle after the request.

Top module: `pktport_dev`

## Requirements
- R1: A read of offset 0x00 returns the low word and a read of 0x04 returns the high word of a 64-bit identifier. The identifier is seven name characters followed by a version character, with the first character in byte 0. With the defaults ("PKTLINK", version "2") the words read 0x4C544B50 and 0x324B4E49.
- R2: Bit 0 of offset 0x08 reads 1 while any of these holds, and 0 otherwise:
  - an inbound packet has started but its last byte has not arrived;
  - the transmit count is nonzero;
  - transmit bytes are still queued.
- R3: When the last inbound byte is accepted, offset 0x0C reads the packet length and bit 1 of offset 0x14 is set, both from the next cycle. A packet longer than RX_DEPTH keeps only its first RX_DEPTH bytes, and the length then reads RX_DEPTH. `rx_ready` is low while bit 1 of 0x14 is set or while the receive count is nonzero.
- R4: A read of offset 0x1C returns the next received byte, in arrival order, in bits 7:0 with the upper bits zero, and lowers the receive count by one. When the count is zero the read returns 0 and the count stays 0.
- R5: A write to offset 0x10 loads the transmit count. Values above 65536 are clamped to 65536. A write to offset 0x20 queues bits 7:0 and lowers the count by one, but only while the count is nonzero and fewer than TX_DEPTH bytes are queued. Any other write to 0x20 is ignored.
- R6: Queued bytes leave on `tx_data` in write order. `tx_valid`, `tx_data` and `tx_last` hold while `tx_ready` is low. `tx_last` is high only with the byte that took the count to zero.
- R7: On the cycle after the byte write that takes the transmit count to zero, bit 0 of offset 0x14 is set and offset 0x10 reads 0.
- R8: Writing 1 to bit 0 or bit 1 of offset 0x14 clears that bit. A completion event in the same cycle wins over the clear.
- R9: A write to offset 0x14 with bit 31 set raises the test bit. A read of 0x14 returns the test bit and then clears it. A write of zero to 0x14 clears it. Other writes leave it unchanged.
- R10: `irq` is high exactly while at least one of bits 0, 1 and 31 of offset 0x14 is set.
- R11: Offset 0x18 reads the IRQ_INFO parameter (default 3), and writes to it have no effect. Offsets outside the register map read 0.
- R12: `host_rdata` changes only on the cycle after a read request and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access request for this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | Byte offset into the register window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| rx_valid | input | 1 | Inbound byte valid |
| rx_ready | output | 1 | Port can take an inbound byte |
| rx_data | input | 8 | Inbound byte |
| rx_last | input | 1 | Inbound byte ends the packet |
| tx_valid | output | 1 | Outbound byte valid |
| tx_ready | input | 1 | Sink takes the outbound byte |
| tx_data | output | 8 | Outbound byte |
| tx_last | output | 1 | Outbound byte ends the packet |
| irq | output | 1 | Interrupt request |

## Verification
Every result is due one clock after its cause:
- read data appears on the cycle after the request;
- the receive flag and length become visible, and `rx_ready` falls, on the cycle after the last inbound byte;
- a written transmit byte appears on `tx_data`, and the transmit-done flag and `irq` rise, on the cycle after the host write.

The bench drives inputs just after a falling edge and updates its behavioural model at the rising edge from the same stable inputs. It compares every output at the following falling edge. As a result, each expectation is sampled exactly one register stage after the stimulus that caused it.

// File: rtl/pktport_pkg.sv
package pktport_pkg;

  localparam int ADDR_W    = 6;
  localparam int COUNT_MAX = 65536;
  localparam int COUNT_W   = $clog2(COUNT_MAX + 1);

  localparam logic [ADDR_W-1:0] OFS_ID_LO  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_ID_HI  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_BUSY   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_RXCNT  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_TXCNT  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_ICTL   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_INFO   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_RXDATA = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_TXDATA = 6'h20;

  localparam int BIT_TXDONE = 0;
  localparam int BIT_RXAVL  = 1;
  localparam int BIT_TEST   = 31;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ID_LO,
    SEL_ID_HI,
    SEL_BUSY,
    SEL_RXCNT,
    SEL_TXCNT,
    SEL_ICTL,
    SEL_INFO,
    SEL_RXDATA,
    SEL_TXDATA
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_ID_LO:  s = SEL_ID_LO;
      OFS_ID_HI:  s = SEL_ID_HI;
      OFS_BUSY:   s = SEL_BUSY;
      OFS_RXCNT:  s = SEL_RXCNT;
      OFS_TXCNT:  s = SEL_TXCNT;
      OFS_ICTL:   s = SEL_ICTL;
      OFS_INFO:   s = SEL_INFO;
      OFS_RXDATA: s = SEL_RXDATA;
      OFS_TXDATA: s = SEL_TXDATA;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

  // Literal text packs its first character highest; the identifier wants it in byte 0.
  function automatic logic [63:0] pack_id(input logic [55:0] name, input logic [7:0] ver);
    logic [63:0] w;
    for (int i = 0; i < 7; i++) begin
      w[8*i +: 8] = name[8*(6-i) +: 8];
    end
    w[63:56] = ver;
    return w;
  endfunction

endpackage

// File: rtl/pktport_rx.sv
module pktport_rx #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  input  logic             hold,
  input  logic             pop,
  output logic [7:0]       pop_data,
  output logic [CNT_W-1:0] count,
  output logic             active,
  output logic             done
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);
  localparam logic [FW-1:0] FILL_MAX = FW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [FW-1:0] fill;
  logic [FW-1:0] fill_nx;
  logic [AW-1:0] rptr;
  logic          accept;
  logic          room;
  logic          has_data;

  assign has_data = (count != '0);
  assign s_ready  = !hold && !has_data;
  assign accept   = s_valid && s_ready;
  assign room     = (fill < FILL_MAX);
  assign fill_nx  = room ? fill + 1'b1 : fill;
  assign done     = accept && s_last;
  assign pop_data = has_data ? mem[rptr] : 8'h00;

  always_ff @(posedge clk) begin
    if (accept && room) begin
      mem[fill[AW-1:0]] <= s_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill   <= '0;
      rptr   <= '0;
      count  <= '0;
      active <= 1'b0;
    end else if (accept) begin
      if (s_last) begin
        fill   <= '0;
        rptr   <= '0;
        count  <= CNT_W'(fill_nx);
        active <= 1'b0;
      end else begin
        fill   <= fill_nx;
        active <= 1'b1;
      end
    end else if (pop && has_data) begin
      count <= count - 1'b1;
      rptr  <= rptr + 1'b1;
    end
  end

endmodule

// File: rtl/pktport_tx.sv
module pktport_tx #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr,
  input  logic [CNT_W-1:0] len_val,
  input  logic             byte_wr,
  input  logic [7:0]       byte_val,
  output logic [CNT_W-1:0] remaining,
  output logic             done,
  output logic             pending,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [7:0]       m_data,
  output logic             m_last
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_TOP = AW'(DEPTH - 1);
  localparam logic [OW-1:0] OCC_MAX = OW'(DEPTH);

  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;
  logic [OW-1:0] occ;
  logic          full;
  logic          push;
  logic          take;
  logic          final_byte;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == PTR_TOP) ? '0 : p + 1'b1;
  endfunction

  assign full       = (occ == OCC_MAX);
  assign final_byte = (remaining == CNT_W'(1));
  assign push       = byte_wr && (remaining != '0) && !full;
  assign m_valid    = (occ != '0);
  assign take       = m_valid && m_ready;
  assign m_data     = mem[rp][7:0];
  assign m_last     = m_valid && mem[rp][8];
  assign pending    = m_valid;
  assign done       = push && final_byte;

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wp] <= {final_byte, byte_val};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      wp        <= '0;
      rp        <= '0;
      occ       <= '0;
    end else begin
      if (len_wr) begin
        remaining <= len_val;
      end else if (push) begin
        remaining <= remaining - 1'b1;
      end
      if (push) begin
        wp <= step(wp);
      end
      if (take) begin
        rp <= step(rp);
      end
      case ({push, take})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

endmodule

// File: rtl/pktport_irq.sv
module pktport_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_set,
  input  logic rx_set,
  input  logic wr_en,
  input  logic clr_tx,
  input  logic clr_rx,
  input  logic wr_zero,
  input  logic wr_test,
  input  logic rd_en,
  output logic tx_flag,
  output logic rx_flag,
  output logic test_flag,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_flag   <= 1'b0;
      rx_flag   <= 1'b0;
      test_flag <= 1'b0;
    end else begin
      if (tx_set) begin
        tx_flag <= 1'b1;
      end else if (wr_en && clr_tx) begin
        tx_flag <= 1'b0;
      end
      if (rx_set) begin
        rx_flag <= 1'b1;
      end else if (wr_en && clr_rx) begin
        rx_flag <= 1'b0;
      end
      if (wr_en) begin
        if (wr_zero) begin
          test_flag <= 1'b0;
        end else if (wr_test) begin
          test_flag <= 1'b1;
        end
      end else if (rd_en) begin
        test_flag <= 1'b0;
      end
    end
  end

  assign irq = tx_flag | rx_flag | test_flag;

endmodule

// File: rtl/pktport_dev.sv
module pktport_dev
  import pktport_pkg::*;
#(
  parameter int          RX_DEPTH = 64,
  parameter int          TX_DEPTH = 4,
  parameter logic [55:0] ID_NAME  = "PKTLINK",
  parameter logic [7:0]  ID_VER   = "2",
  parameter logic [31:0] IRQ_INFO = 32'h0000_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              irq
);
  localparam int CNT_W = COUNT_W;
  localparam logic [63:0] ID_WORD = pack_id(ID_NAME, ID_VER);
  localparam logic [31:0] CLAMP32 = 32'(COUNT_MAX);

  reg_sel_e         sel;
  logic             rd_req;
  logic             wr_req;
  logic             rx_pop;
  logic [7:0]       rx_byte;
  logic [CNT_W-1:0] rx_count;
  logic             rx_active;
  logic             rx_done_evt;
  logic             len_wr;
  logic             byte_wr;
  logic [CNT_W-1:0] len_val;
  logic [CNT_W-1:0] tx_count;
  logic             tx_done_evt;
  logic             tx_pending;
  logic             tx_flag;
  logic             rx_flag;
  logic             test_flag;
  logic             ictl_wr;
  logic             ictl_rd;
  logic             busy;
  logic [31:0]      rd_mux;

  assign sel     = decode_addr(host_addr);
  assign rd_req  = host_sel && !host_wr;
  assign wr_req  = host_sel && host_wr;
  assign rx_pop  = rd_req && (sel == SEL_RXDATA);
  assign len_wr  = wr_req && (sel == SEL_TXCNT);
  assign byte_wr = wr_req && (sel == SEL_TXDATA);
  assign ictl_wr = wr_req && (sel == SEL_ICTL);
  assign ictl_rd = rd_req && (sel == SEL_ICTL);
  assign len_val = (host_wdata > CLAMP32) ? CNT_W'(COUNT_MAX) : host_wdata[CNT_W-1:0];
  assign busy    = rx_active || (tx_count != '0) || tx_pending;

  pktport_rx #(
    .DEPTH (RX_DEPTH),
    .CNT_W (CNT_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (rx_valid),
    .s_ready  (rx_ready),
    .s_data   (rx_data),
    .s_last   (rx_last),
    .hold     (rx_flag),
    .pop      (rx_pop),
    .pop_data (rx_byte),
    .count    (rx_count),
    .active   (rx_active),
    .done     (rx_done_evt)
  );

  pktport_tx #(
    .DEPTH (TX_DEPTH),
    .CNT_W (CNT_W)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_wr    (len_wr),
    .len_val   (len_val),
    .byte_wr   (byte_wr),
    .byte_val  (host_wdata[7:0]),
    .remaining (tx_count),
    .done      (tx_done_evt),
    .pending   (tx_pending),
    .m_valid   (tx_valid),
    .m_ready   (tx_ready),
    .m_data    (tx_data),
    .m_last    (tx_last)
  );

  pktport_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_set    (tx_done_evt),
    .rx_set    (rx_done_evt),
    .wr_en     (ictl_wr),
    .clr_tx    (host_wdata[BIT_TXDONE]),
    .clr_rx    (host_wdata[BIT_RXAVL]),
    .wr_zero   (host_wdata == 32'h0),
    .wr_test   (host_wdata[BIT_TEST]),
    .rd_en     (ictl_rd),
    .tx_flag   (tx_flag),
    .rx_flag   (rx_flag),
    .test_flag (test_flag),
    .irq       (irq)
  );

  always_comb begin
    rd_mux = 32'h0;
    case (sel)
      SEL_ID_LO:  rd_mux = ID_WORD[31:0];
      SEL_ID_HI:  rd_mux = ID_WORD[63:32];
      SEL_BUSY:   rd_mux = {31'h0, busy};
      SEL_RXCNT:  rd_mux = 32'(rx_count);
      SEL_TXCNT:  rd_mux = 32'(tx_count);
      SEL_ICTL:   rd_mux = {test_flag, 29'h0, rx_flag, tx_flag};
      SEL_INFO:   rd_mux = IRQ_INFO;
      SEL_RXDATA: rd_mux = {24'h0, rx_byte};
      default:    rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= 32'h0;
    end else if (rd_req) begin
      host_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/pktport_dev_chk.sv
module pktport_dev_chk #(
  parameter int RX_DEPTH = 64,
  parameter int CNT_W    = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_sel,
  input logic             host_wr,
  input logic [5:0]       host_addr,
  input logic             rx_ready,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_last,
  input logic             irq,
  input logic             rx_flag,
  input logic [CNT_W-1:0] rx_count,
  input logic             tx_done_evt
);

  // R3: a pending receive flag blocks the inbound stream
  p_rx_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag |-> !rx_ready);

  // R3: the stored length never exceeds the buffer
  p_rx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(RX_DEPTH));

  // R4: reading an empty data port leaves the count at zero
  p_rx_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_wr && host_addr == 6'h1C && rx_count == '0 && !rx_ready) |=> (rx_count == '0));

  // R6: an offered byte is held until taken
  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R7: completion of a transmit raises the interrupt next cycle
  p_txdone_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_evt |=> irq);

endmodule

bind pktport_dev pktport_dev_chk #(
  .RX_DEPTH (RX_DEPTH),
  .CNT_W    (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_sel    (host_sel),
  .host_wr     (host_wr),
  .host_addr   (host_addr),
  .rx_ready    (rx_ready),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data),
  .tx_last     (tx_last),
  .irq         (irq),
  .rx_flag     (rx_flag),
  .rx_count    (rx_count),
  .tx_done_evt (tx_done_evt)
);

// File: tb/sim_pktport_dev.sv
`timescale 1ns/1ps
module sim_pktport_dev;
  localparam int RXD = 64;
  localparam int TXD = 4;
  localparam logic [31:0] EXP_ID_LO = 32'h4C544B50;
  localparam logic [31:0] EXP_ID_HI = 32'h324B4E49;
  localparam logic [31:0] EXP_INFO  = 32'h0000_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid, tx_last, irq;
  logic        tx_ready;
  logic [7:0]  tx_data;

  int nvec = 0, nerr = 0;
  bit live = 0, finished = 0;
  int tx_mode = 0;

  always #5 clk = ~clk;

  pktport_dev #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .irq(irq)
  );

  // behavioural reference model
  bit          m_rxf, m_txf, m_test, m_active, m_rd_last;
  int          m_rxcnt, m_txrem;
  logic [7:0]  m_rxbuf[$];
  logic [7:0]  m_wq[$];
  logic [8:0]  m_txq[$];
  logic [31:0] m_rdata;
  logic [5:0]  m_rd_addr;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic string rtag(input logic [5:0] a);
    case (a)
      6'h00, 6'h04: return "R1 id read";
      6'h08:        return "R2 busy read";
      6'h0C:        return "R3 rx count read";
      6'h10:        return "R5 tx count read";
      6'h14:        return "R9 ctl read";
      6'h1C:        return "R4 rx data read";
      default:      return "R11 info/unmapped read";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rxf = 0; m_txf = 0; m_test = 0; m_active = 0; m_rd_last = 0;
      m_rxcnt = 0; m_txrem = 0; m_rxbuf = {}; m_wq = {}; m_txq = {};
      m_rdata = 0; m_rd_addr = 0;
    end else begin
      bit acc, txpop, full_pre, rxset, txset;
      logic [31:0] rv;
      acc      = rx_valid && !m_rxf && (m_rxcnt == 0);
      txpop    = (m_txq.size() != 0) && tx_ready;
      full_pre = (m_txq.size() >= TXD);
      rxset = 0; txset = 0; m_rd_last = 0;
      if (host_sel && !host_wr) begin
        rv = 0;
        case (host_addr)
          6'h00: rv = EXP_ID_LO;
          6'h04: rv = EXP_ID_HI;
          6'h08: rv = (m_active || m_txrem != 0 || m_txq.size() != 0) ? 1 : 0;
          6'h0C: rv = m_rxcnt;
          6'h10: rv = m_txrem;
          6'h14: begin rv = {m_test, 29'h0, m_rxf, m_txf}; m_test = 0; end
          6'h18: rv = EXP_INFO;
          6'h1C: if (m_rxcnt > 0) begin rv = {24'h0, m_rxbuf.pop_front()}; m_rxcnt--; end
          default: rv = 0;
        endcase
        m_rdata = rv; m_rd_last = 1; m_rd_addr = host_addr;
      end
      if (host_sel && host_wr) begin
        case (host_addr)
          6'h10: m_txrem = (host_wdata > 65536) ? 65536 : int'(host_wdata);
          6'h14: begin
            if (host_wdata[0]) m_txf = 0;
            if (host_wdata[1]) m_rxf = 0;
            if (host_wdata == 0) m_test = 0;
            else if (host_wdata[31]) m_test = 1;
          end
          6'h20: if (m_txrem > 0 && !full_pre) begin
            m_txq.push_back({(m_txrem == 1), host_wdata[7:0]});
            if (m_txrem == 1) txset = 1;
            m_txrem--;
          end
          default: ;
        endcase
      end
      if (txpop) void'(m_txq.pop_front());
      if (acc) begin
        if (m_wq.size() < RXD) m_wq.push_back(rx_data);
        if (rx_last) begin
          m_rxbuf = m_wq; m_wq = {}; m_rxcnt = m_rxbuf.size();
          rxset = 1; m_active = 0;
        end else m_active = 1;
      end
      if (rxset) m_rxf = 1;
      if (txset) m_txf = 1;
    end
  end

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (live && rst_n && !finished) begin
      chk(rx_ready, (!m_rxf && m_rxcnt == 0), "R3 rx_ready");
      chk(tx_valid, (m_txq.size() != 0), "R6 tx_valid");
      if (m_txq.size() != 0) begin
        chk(tx_data, m_txq[0][7:0], "R6 tx_data");
        chk(tx_last, m_txq[0][8], "R6 tx_last");
      end
      chk(irq, (m_rxf || m_txf || m_test), "R10 irq");
      chk(host_rdata, m_rdata, m_rd_last ? rtag(m_rd_addr) : "R12 rdata hold");
    end
  end

  initial begin
    tx_ready = 1'b1;
    forever begin
      @(negedge clk); #1;
      case (tx_mode)
        0: tx_ready = 1'b1;
        1: tx_ready = ~tx_ready;
        default: tx_ready = 1'b0;
      endcase
    end
  end

  task automatic hwrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_sel = 0; host_wr = 0;
  endtask

  task automatic hread(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    host_sel = 1; host_wr = 0; host_addr = a;
    @(posedge clk); #1;
    host_sel = 0;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic rx_send(input int n, input int base, input bit with_last, input bit gaps);
    for (int i = 0; i < n; i++) begin
      bit ok;
      @(negedge clk); #1;
      rx_valid = 1; rx_data = 8'(base + i); rx_last = with_last && (i == n - 1);
      forever begin
        ok = rx_ready;
        @(posedge clk);
        if (ok) break;
        @(negedge clk); #1;
      end
      #1; rx_valid = 0; rx_last = 0;
      if (gaps && (i % 2 == 0)) @(posedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(host_rdata, 32'h0, "R12 reset rdata");
    chk(irq, 1'b0, "R10 reset irq");
    chk(tx_valid, 1'b0, "R6 reset tx_valid");
    #1; rst_n = 1; live = 1;
    @(negedge clk);
    chk(rx_ready, 1'b1, "R3 reset rx_ready");

    // identification, info, unmapped
    hread(6'h00, d); chk(d, EXP_ID_LO, "R1 id low");
    hread(6'h04, d); chk(d, EXP_ID_HI, "R1 id high");
    hread(6'h08, d); chk(d, 32'h0, "R2 idle busy");
    hread(6'h18, d); chk(d, EXP_INFO, "R11 info");
    hwrite(6'h18, 32'hFFFF_FFFF);
    hread(6'h18, d); chk(d, EXP_INFO, "R11 info after write");
    hread(6'h24, d); chk(d, 32'h0, "R11 unmapped");

    // test bit
    hwrite(6'h14, 32'h8000_0000);
    @(negedge clk); chk(irq, 1'b1, "R9 test raises irq");
    hread(6'h14, d); chk(d, 32'h8000_0000, "R9 test read");
    @(negedge clk); chk(irq, 1'b0, "R9 cleared by read");
    hwrite(6'h14, 32'h8000_0000);
    hwrite(6'h14, 32'h0);
    @(negedge clk); chk(irq, 1'b0, "R9 cleared by zero write");
    hwrite(6'h14, 32'h8000_0000);
    hwrite(6'h14, 32'h0000_0001);
    hread(6'h14, d); chk(d, 32'h8000_0000, "R9 kept by clear-only write");

    // receive with gaps
    rx_send(5, 8'hA0, 1, 1);
    @(negedge clk); chk(rx_ready, 1'b0, "R3 ready low after packet");
    hread(6'h0C, d); chk(d, 32'd5, "R3 length");
    hread(6'h14, d); chk(d, 32'h2, "R3 rx flag");
    hread(6'h1C, d); chk(d, 32'hA0, "R4 byte 0");
    hread(6'h1C, d); chk(d, 32'hA1, "R4 byte 1");
    hread(6'h0C, d); chk(d, 32'd3, "R4 count decrement");
    hwrite(6'h14, 32'h2);
    @(negedge clk);
    chk(irq, 1'b0, "R8 rx clear");
    chk(rx_ready, 1'b0, "R3 ready low while count nonzero");
    for (int i = 2; i < 5; i++) begin
      hread(6'h1C, d); chk(d, 32'(8'hA0 + i), "R4 byte order");
    end
    hread(6'h1C, d); chk(d, 32'h0, "R4 empty read");
    hread(6'h0C, d); chk(d, 32'h0, "R4 count stays zero");

    // blocked by pending flag
    rx_send(3, 8'h10, 1, 0);
    for (int i = 0; i < 3; i++) hread(6'h1C, d);
    @(negedge clk); #1;
    rx_valid = 1; rx_data = 8'h55; rx_last = 1;
    idle(4);
    @(negedge clk); chk(rx_ready, 1'b0, "R3 blocked by flag");
    #1; rx_valid = 0; rx_last = 0;
    hwrite(6'h14, 32'h2);
    hread(6'h0C, d); chk(d, 32'h0, "R3 blocked byte not taken");

    // busy during a partial packet
    rx_send(2, 8'h30, 0, 0);
    hread(6'h08, d); chk(d, 32'h1, "R2 busy partial rx");
    rx_send(1, 8'h32, 1, 0);
    hread(6'h08, d); chk(d, 32'h0, "R2 busy clear after rx");
    for (int i = 0; i < 3; i++) hread(6'h1C, d);
    hwrite(6'h14, 32'h2);

    // truncation
    rx_send(RXD + 6, 8'h40, 1, 0);
    hread(6'h0C, d); chk(d, 32'(RXD), "R3 truncated length");
    for (int i = 0; i < RXD; i++) hread(6'h1C, d);
    chk(d, 32'(8'(8'h40 + RXD - 1)), "R3 last kept byte");
    hwrite(6'h14, 32'h2);

    // transmit with toggling ready
    tx_mode = 1;
    hwrite(6'h10, 32'd3);
    hread(6'h08, d); chk(d, 32'h1, "R2 busy tx");
    hwrite(6'h20, 32'hFFFF_FF11);
    hwrite(6'h20, 32'h0000_0122);
    hwrite(6'h20, 32'h0000_0033);
    @(negedge clk); chk(irq, 1'b1, "R7 done irq");
    hread(6'h10, d); chk(d, 32'h0, "R7 count zero");
    hread(6'h14, d); chk(d, 32'h1, "R7 done flag");
    idle(10);
    hwrite(6'h14, 32'h1);
    @(negedge clk); chk(irq, 1'b0, "R8 tx clear");

    // ignored write with count zero
    hwrite(6'h20, 32'h99);
    idle(3);
    @(negedge clk); chk(tx_valid, 1'b0, "R5 write ignored at zero count");

    // queue full under back-pressure
    tx_mode = 2;
    hwrite(6'h10, 32'd6);
    for (int i = 0; i < 6; i++) hwrite(6'h20, 32'(8'h60 + i));
    hread(6'h10, d); chk(d, 32'd2, "R5 full drops writes");
    idle(5);
    tx_mode = 0;
    idle(8);
    hwrite(6'h20, 32'h7A);
    hwrite(6'h20, 32'h7B);
    idle(4);
    hread(6'h14, d); chk(d, 32'h1, "R7 done after refill");
    hwrite(6'h14, 32'h1);

    // clamp
    hwrite(6'h10, 32'h0003_0000);
    hread(6'h10, d); chk(d, 32'h0001_0000, "R5 clamp");
    hwrite(6'h10, 32'h0);
    hread(6'h08, d); chk(d, 32'h0, "R2 idle at end");

    idle(4);
    finish_run();
  end

endmodule